// File: doc/BRIEF.md
# Smart Card Guard Interval Monitor

This block watches the shared smart card data line and tells software whether enough time has passed since the most recent character began. Every character, whether the reader or the card sends it, opens with a falling edge on the line. The monitor restarts an interval counter on each such edge. It raises a status flag once the interval has run out without a new character appearing. The interval is counted in elementary time units (ETU). An external baud divider supplies one single-cycle tick per ETU.

The required interval depends on the transmission protocol. Block-oriented protocol T=1 needs 22 ETU and character-oriented protocol T=0 needs 16 ETU. The protocol is sampled at each start bit, so the interval already running keeps its length.

A character that begins before the interval is complete produces a one-cycle violation pulse. This catches a card that answers too early and also a reader that transmits too early. The status flag is only polled; a one-register read port returns it.

Top module: `sc_guard_monitor`

## Requirements
- R1: The data line passes through a two-flop synchroniser, and a start bit is a high-to-low transition of the synchronised line. The effects of a start bit (status cleared, violation pulse) are visible on the outputs three clock edges after `io_line` falls.
- R2: When the protocol sampled at the last start bit is T=1 (`proto_t1`=1), `guard_ok` becomes 1 at the 22nd ETU tick after that start bit and not earlier.
- R3: When the protocol sampled at the last start bit is T=0 (`proto_t1`=0), `guard_ok` becomes 1 at the 16th ETU tick after that start bit and not earlier.
- R4: The counter saturates at the selected limit, so `guard_ok` stays 1 through any number of further ticks until the next start bit.
- R5: Every accepted start bit clears `guard_ok` to 0 and restarts the count from zero in the same cycle, whichever side is sending.
- R6: An accepted start bit that arrives while `guard_ok` is 0, after an earlier start bit, produces `guard_violation` high for exactly one cycle. A start bit arriving while `guard_ok` is 1 produces no pulse.
- R7: Falling edges during the 10 ETU ticks after an accepted start bit are ignored: they neither clear `guard_ok`, nor restart the count, nor pulse `guard_violation`.
- R8: A change of `proto_t1` while an interval is running has no effect on that interval's length.
- R9: After reset `guard_ok` and `guard_violation` are 0, and ETU ticks before the first start bit do not set `guard_ok`. The first start bit never pulses `guard_violation`.
- R10: A cycle with `rd_en` high yields `rd_valid` high in the next cycle. In that cycle `rd_data` bit 0 holds the `guard_ok` value from the request cycle and all other bits are 0. Reading does not change `guard_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| io_line | input | 1 | Asynchronous smart card data line, idle high |
| proto_t1 | input | 1 | 1 selects T=1 (22 ETU), 0 selects T=0 (16 ETU) |
| rd_en | input | 1 | Status read request |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | RD_W | Read data, bit 0 is the guard status |
| guard_ok | output | 1 | Guard interval elapsed since the last start bit |
| guard_violation | output | 1 | One-cycle pulse on a start bit that arrives too early |

## Verification
The main stimulus is a table of tick counts placed between consecutive start bits. Each protocol is run at one tick short of its limit, exactly at its limit, and well beyond it, which separates an off-by-one limit from a correct one and shows that saturation holds. In every row the protocol select is flipped after the start bit, so a monitor that reads the select live instead of latching it counts to the wrong limit. Directed cases then place a falling edge inside the 10-ETU frame window to tell masking apart from a restart, give ticks before any start bit, and read the status through the read port.

// File: rtl/sc_guard_pkg.sv
package sc_guard_pkg;
    typedef enum logic {
        PROTO_T0 = 1'b0,
        PROTO_T1 = 1'b1
    } proto_e;

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sc_io_sync.sv
module sc_io_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_async,
    output logic io_fall
);
    localparam int unsigned LAST = STAGES;

    // stages 0..STAGES-1 synchronise, stage STAGES holds the previous value
    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], io_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign io_fall = sh_q[LAST] && !sh_q[LAST-1];

    assert_fall_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        io_fall |=> !io_fall);
endmodule

// File: rtl/sc_frame_mask.sv
module sc_frame_mask #(
    parameter int unsigned FRAME_ETU = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic etu_tick,
    input  logic io_fall,
    output logic start
);
    localparam int unsigned CW = $clog2(FRAME_ETU + 1);
    localparam logic [CW-1:0] LAST_TICK = CW'(FRAME_ETU - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } mask_st_t;

    mask_st_t st_d, st_q;

    assign start = io_fall && !st_q.busy;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy && etu_tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_TICK) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_mask_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.busy && st_q.cnt == '0);
    assert_mask_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.cnt < CW'(FRAME_ETU));
endmodule

// File: rtl/sc_guard_timer.sv
module sc_guard_timer #(
    parameter int unsigned T0_ETU = 16,
    parameter int unsigned T1_ETU = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic etu_tick,
    input  logic start,
    input  logic proto_t1,
    output logic guard_ok,
    output logic guard_violation
);
    import sc_guard_pkg::*;

    localparam int unsigned MAXL = max_of(T0_ETU, T1_ETU);
    localparam int unsigned CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] LIM_T0 = CW'(T0_ETU);
    localparam logic [CW-1:0] LIM_T1 = CW'(T1_ETU);

    typedef struct packed {
        logic          started;
        logic [CW-1:0] cnt;
        logic [CW-1:0] limit;
        logic          ok;
        logic          viol;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    proto_e  proto;

    assign proto = proto_e'(proto_t1);

    always_comb begin
        st_d      = st_q;
        st_d.viol = 1'b0;
        if (start) begin
            st_d.started = 1'b1;
            st_d.cnt     = '0;
            st_d.ok      = 1'b0;
            st_d.limit   = (proto == PROTO_T1) ? LIM_T1 : LIM_T0;
            st_d.viol    = st_q.started && !st_q.ok;
        end else if (st_q.started && etu_tick && !st_q.ok) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == st_q.limit) st_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign guard_ok        = st_q.ok;
    assign guard_violation = st_q.viol;

    assert_ok_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ok |-> st_q.cnt == st_q.limit);
    assert_limit_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started |-> (st_q.limit == LIM_T0 || st_q.limit == LIM_T1));
    assert_ok_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ok && !start |=> st_q.ok);
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !st_q.ok && st_q.cnt == '0);
    assert_viol_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.viol |=> !st_q.viol);
    assert_limit_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(st_q.limit));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.started |-> !st_q.ok && !st_q.viol);
endmodule

// File: rtl/sc_guard_monitor.sv
module sc_guard_monitor #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FRAME_ETU   = 10,
    parameter int unsigned T0_ETU      = 16,
    parameter int unsigned T1_ETU      = 22,
    parameter int unsigned RD_W        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            etu_tick,
    input  logic            io_line,
    input  logic            proto_t1,
    input  logic            rd_en,
    output logic            rd_valid,
    output logic [RD_W-1:0] rd_data,
    output logic            guard_ok,
    output logic            guard_violation
);
    logic io_fall;
    logic start;

    sc_io_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_async (io_line),
        .io_fall  (io_fall)
    );

    sc_frame_mask #(.FRAME_ETU(FRAME_ETU)) mask_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .etu_tick (etu_tick),
        .io_fall  (io_fall),
        .start    (start)
    );

    sc_guard_timer #(.T0_ETU(T0_ETU), .T1_ETU(T1_ETU)) timer_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .etu_tick        (etu_tick),
        .start           (start),
        .proto_t1        (proto_t1),
        .guard_ok        (guard_ok),
        .guard_violation (guard_violation)
    );

    typedef struct packed {
        logic            valid;
        logic [RD_W-1:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = rd_en ? RD_W'(guard_ok) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    assert_rd_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid && rd_data[0] == $past(guard_ok));
    assert_rd_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> 1) == '0);
endmodule

// File: tb/sc_guard_monitor_tb_top.sv
module sc_guard_monitor_tb_top;
    localparam int RD_W = 8;
    localparam int NV   = 6;
    // table: protocol latched at the start bit, ticks until next start, expected guard_ok
    localparam bit VPROTO [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam int VTICKS [NV] = '{15,   16,   21,   22,   30,   40};
    localparam bit VOK    [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic etu_tick = 1'b0;
    logic io_line = 1'b1;
    logic proto_t1 = 1'b0;
    logic rd_en = 1'b0;
    logic rd_valid;
    logic [RD_W-1:0] rd_data;
    logic guard_ok;
    logic guard_violation;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sc_guard_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .io_line(io_line),
        .proto_t1(proto_t1), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .guard_ok(guard_ok), .guard_violation(guard_violation)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) etu_tick = 1'b1;
            @(negedge clk) etu_tick = 1'b0;
        end
    endtask

    // falling edge on the line; outputs checked after three edges
    task automatic start_bit(input bit exp_viol, input string req);
        @(negedge clk) io_line = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({req, " violation"}, guard_violation, exp_viol);
        check("R5 status cleared", guard_ok, 1'b0);
        @(negedge clk);
        check("R6 pulse width", guard_violation, 1'b0);
        io_line = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_check(input bit exp_ok);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        check("R10 rd_valid", rd_valid, 1'b1);
        check("R10 rd_data", rd_data, RD_W'(exp_ok));
        check("R10 status kept", guard_ok, exp_ok);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset guard_ok", guard_ok, 1'b0);
        check("R9 reset violation", guard_violation, 1'b0);
        check("R10 reset rd_valid", rd_valid, 1'b0);
        rst_n = 1'b1;
        ticks(30);
        check("R9 idle ticks ignored", guard_ok, 1'b0);
        read_check(1'b0);

        // table walk; protocol flipped after each start bit (R8)
        for (int v = 0; v < NV; v++) begin
            proto_t1 = VPROTO[v];
            if (v == 0) start_bit(1'b0, "R9 first start");
            else        start_bit(!VOK[v-1], "R6");
            proto_t1 = !VPROTO[v];
            ticks(VTICKS[v] - 1);
            check(VPROTO[v] ? "R2 before limit" : "R3 before limit",
                  guard_ok, (VTICKS[v] - 1) >= (VPROTO[v] ? 22 : 16));
            ticks(1);
            check(VPROTO[v] ? "R2/R8 T1 row" : "R3/R8 T0 row", guard_ok, VOK[v]);
        end
        check("R4 saturated", guard_ok, 1'b1);
        read_check(1'b1);

        // R7: falling edge inside the frame window is ignored
        proto_t1 = 1'b0;
        start_bit(1'b0, "R6 late start");
        ticks(5);
        start_bit(1'b0, "R7 masked edge");
        ticks(11);
        check("R7 count not restarted", guard_ok, 1'b1);

        // R6: early start after 12 ticks
        start_bit(1'b0, "R6 on-time");
        ticks(12);
        start_bit(1'b1, "R6 early start");
        ticks(16);
        check("R3 after early start", guard_ok, 1'b1);
        ticks(5);
        check("R4 still set", guard_ok, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule